// File: doc/BRIEF.md
# Edge-Selectable Serial Command Receiver

This block takes command bytes from a host over a write-only three-wire synchronous link. The wires are an active-low select, a serial clock and a data line. A fast system clock oversamples all three wires. A static strap input decides which serial-clock edge captures data: the rising edge when the strap is low, the falling edge when it is high. Bits arrive most-significant first. Every eighth captured bit completes a byte, and the byte goes to a downstream command decoder with a one-cycle valid strobe.

The receiver knows which opcodes take a second data byte. A byte whose upper nibble is 0100 or 0111 announces a two-byte command. The byte after it is marked with a second-byte flag, so the decoder does not need to track framing itself. Raising select clears the bit count and any pending two-byte state. A host can therefore resynchronise after noise on the clock line by pulsing select.

Top module: `scmd_rx`

## Requirements
- R1: Bits are shifted in most-significant first. The byte on `byte_data` equals the eight data-line values at eight consecutive capture edges, the first of them landing in bit 7.
- R2: While `fall_sel` is 0, only rising transitions of `sck` capture data, and falling transitions have no effect on the assembled byte.
- R3: While `fall_sel` is 1, only falling transitions of `sck` capture data, and rising transitions have no effect on the assembled byte.
- R4: `byte_vld` stays high for exactly one system-clock cycle per completed byte. It is first seen high after the third rising `clk` edge that follows the eighth capturing `sck` transition. `byte_data` changes only together with `byte_vld`.
- R5: With `cs_n` held low, any number of bytes can be received back to back without releasing select.
- R6: Driving `cs_n` high clears the bit count and discards a partial byte, so the next byte after select falls again is assembled correctly.
- R7: `sck` transitions while `cs_n` is high capture nothing and produce no strobe.
- R8: A first byte whose bits [7:4] are 0100 or 0111 makes the next byte carry `byte_second` = 1. After a first byte with any other upper nibble, the next byte carries `byte_second` = 0.
- R9: A byte delivered with `byte_second` = 1 is never read as an opcode, so the byte after it carries `byte_second` = 0 whatever its own value.
- R10: If `cs_n` rises between the first and second byte of a two-byte command, the pending state is dropped and the next byte carries `byte_second` = 0.
- R11: While `rst` is high and just after it, `byte_vld`, `byte_data` and `byte_second` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Link select, active low, asynchronous to `clk` |
| sck | input | 1 | Serial clock, asynchronous to `clk` |
| sdi | input | 1 | Serial data, asynchronous to `clk` |
| fall_sel | input | 1 | Static strap: 0 captures on rising `sck`, 1 on falling `sck` |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Assembled byte, held until the next strobe |
| byte_second | output | 1 | Marks the byte as the data byte of a two-byte command |

## Verification
A capturing `sck` transition needs two synchroniser stages and one edge-detect comparison. It then takes one framer register, so the strobe is due after the third rising `clk` edge following the transition. The bench drives every link change on a falling `clk` edge. It steps exactly three rising edges after the eighth capture transition and samples one time unit later, where it expects `byte_vld`, `byte_data` and `byte_second`. One edge later it expects the strobe gone. A free-running counter of strobes sampled on falling edges checks that partial bytes and edges with select high add no strobe at all.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
   localparam int OP_W = 4;
   localparam logic [OP_W-1:0] OP_PLAY_LIKE  = 4'b0100;
   localparam logic [OP_W-1:0] OP_QUIET_LIKE = 4'b0111;

   function automatic logic takes_operand(input logic [OP_W-1:0] op);
      return (op == OP_PLAY_LIKE) || (op == OP_QUIET_LIKE);
   endfunction
endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scmd_edge.sv
module scmd_edge (
   input  logic clk,
   input  logic rst,
   input  logic sck_s,
   input  logic cs_s,
   input  logic fall_s,
   output logic cap
);
   logic sck_d;
   logic rise_w;
   logic fall_w;

   always_ff @(posedge clk) begin
      if (rst) sck_d <= 1'b0;
      else     sck_d <= sck_s;
   end

   assign rise_w = sck_s & ~sck_d;
   assign fall_w = ~sck_s & sck_d;
   assign cap    = ~cs_s & (fall_s ? fall_w : rise_w);
endmodule

// File: rtl/scmd_framer.sv
module scmd_framer
   import scmd_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic              bit_in,
   input  logic              cs_s,
   output logic              vld,
   output logic [BYTE_W-1:0] data,
   output logic              second
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              pend;
   logic [BYTE_W-1:0] next_byte;

   assign next_byte = {shreg[BYTE_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg  <= '0;
         cnt    <= '0;
         pend   <= 1'b0;
         vld    <= 1'b0;
         data   <= '0;
         second <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (cs_s) begin
            cnt  <= '0;
            pend <= 1'b0;
         end else if (cap) begin
            shreg <= next_byte;
            if (cnt == LAST) begin
               cnt    <= '0;
               vld    <= 1'b1;
               data   <= next_byte;
               second <= pend;
               pend   <= ~pend & takes_operand(next_byte[BYTE_W-1 -: OP_W]);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/scmd_rx.sv
module scmd_rx
   import scmd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic              fall_sel,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data,
   output logic              byte_second
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scmd_rx: SYNC_STAGES must be at least 2");
   end
   if (BYTE_W < OP_W + 1) begin : g_bad_width
      $error("scmd_rx: BYTE_W must exceed the opcode width");
   end

   localparam int NSIG = 4;
   localparam logic [NSIG-1:0] SYNC_RST = 4'b0001;

   logic [NSIG-1:0] raw_w;
   logic [NSIG-1:0] syn_w;
   logic            cap_w;

   assign raw_w = {fall_sel, sdi, sck, cs_n};

   scmd_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_w),
      .q   (syn_w)
   );

   scmd_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .sck_s  (syn_w[1]),
      .cs_s   (syn_w[0]),
      .fall_s (syn_w[3]),
      .cap    (cap_w)
   );

   scmd_framer #(.BYTE_W(BYTE_W)) u_framer (
      .clk    (clk),
      .rst    (rst),
      .cap    (cap_w),
      .bit_in (syn_w[2]),
      .cs_s   (syn_w[0]),
      .vld    (byte_vld),
      .data   (byte_data),
      .second (byte_second)
   );
endmodule

// File: rtl/scmd_rx_chk.sv
module scmd_rx_chk
   import scmd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              byte_vld,
   input logic [BYTE_W-1:0] byte_data,
   input logic              byte_second
);
   logic [SYNC_STAGES:0] cs_hist;
   logic                 pend_m;
   logic                 last_sec_m;

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_hist    <= '1;
         pend_m     <= 1'b0;
         last_sec_m <= 1'b0;
      end else begin
         cs_hist <= {cs_hist[SYNC_STAGES-1:0], cs_n};
         if (byte_vld) begin
            pend_m     <= ~byte_second & takes_operand(byte_data[BYTE_W-1 -: OP_W]);
            last_sec_m <= byte_second;
         end
      end
   end

   // R4: strobe lasts one cycle
   a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
      byte_vld |=> !byte_vld);

   // R4: data moves only with the strobe
   a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(byte_data) |-> byte_vld);

   // R7: a strobe needs select low when the final capture edge was sampled
   a_r7_select_gate: assert property (@(posedge clk) disable iff (rst)
      byte_vld |-> !cs_hist[SYNC_STAGES]);

   // R8: second-byte flag only after a two-byte opcode
   a_r8_second_after_op: assert property (@(posedge clk) disable iff (rst)
      (byte_vld && byte_second) |-> pend_m);

   // R9: never two second bytes in a row
   a_r9_no_double_second: assert property (@(posedge clk) disable iff (rst)
      (byte_vld && byte_second) |-> !last_sec_m);

   // R11: outputs idle under reset
   always @(negedge clk) begin
      if (rst) begin
         a_r11_reset_idle: assert (!byte_vld && !byte_second);
      end
   end
endmodule

bind scmd_rx scmd_rx_chk #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cs_n        (cs_n),
   .byte_vld    (byte_vld),
   .byte_data   (byte_data),
   .byte_second (byte_second)
);

// File: tb/scmd_rx_tb.sv
`timescale 1ns/1ps
module scmd_rx_tb_top;
   localparam int HALF = 42;

   logic       clk = 1'b0;
   logic       rst;
   logic       cs_n;
   logic       sck;
   logic       sdi;
   logic       fall_sel;
   logic       byte_vld;
   logic [7:0] byte_data;
   logic       byte_second;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   int exp_strobes = 0;
   bit pend_b = 1'b0;

   always #2.5 clk = ~clk;

   scmd_rx dut_i (
      .clk         (clk),
      .rst         (rst),
      .cs_n        (cs_n),
      .sck         (sck),
      .sdi         (sdi),
      .fall_sel    (fall_sel),
      .byte_vld    (byte_vld),
      .byte_data   (byte_data),
      .byte_second (byte_second)
   );

   always @(negedge clk) if (byte_vld) strobes++;

   function automatic bit opens_pair(input logic [7:0] v);
      return (v[7:4] == 4'h4) || (v[7:4] == 4'h7);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic select_high();
      @(negedge clk);
      cs_n = 1'b1;
      wait_neg(10);
      pend_b = 1'b0;
   endtask

   task automatic select_low();
      @(negedge clk);
      cs_n = 1'b0;
      wait_neg(10);
   endtask

   task automatic set_mode(input logic m);
      select_high();
      fall_sel = m;
      sck = m;
      wait_neg(10);
   endtask

   // One bit: data, capture transition, return to idle level
   task automatic clock_bits(input logic [7:0] v, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk);
         sdi = v[i];
         wait_neg(HALF);
         sck = ~sck;
         wait_neg(HALF);
         sck = ~sck;
      end
   endtask

   task automatic send_byte(input logic [7:0] v, input string req);
      bit exp_sec;
      exp_sec = pend_b;
      clock_bits(v, 7);
      @(negedge clk);
      sdi = v[0];
      wait_neg(HALF);
      sck = ~sck;
      repeat (2) @(posedge clk);
      #1 chk(byte_vld == 1'b0, "R4", "strobe early", byte_vld, 0);
      @(posedge clk);
      #1 chk(byte_vld == 1'b1, "R4", "strobe due", byte_vld, 1);
      chk(byte_data == v, req, "data", byte_data, v);
      chk(byte_second == exp_sec, "R8", "second flag", byte_second, exp_sec);
      @(posedge clk);
      #1 chk(byte_vld == 1'b0, "R4", "strobe width", byte_vld, 0);
      exp_strobes++;
      pend_b = exp_sec ? 1'b0 : opens_pair(v);
      wait_neg(HALF);
      sck = ~sck;
   endtask

   initial begin
      #(5.0 * 195000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int s0;
      logic [7:0] v;
      void'($urandom(32'h5c3d_0101));
      rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; fall_sel = 1'b0;
      wait_neg(6);
      chk(byte_vld == 0 && byte_data == 0 && byte_second == 0, "R11",
          "reset outputs", {byte_vld, byte_second, byte_data}, 0);
      rst = 1'b0;
      wait_neg(4);
      chk(byte_vld == 0 && byte_data == 0, "R11", "after reset",
          {byte_vld, byte_data}, 0);

      // rising-edge capture
      select_low();
      send_byte(8'hA5, "R1");
      send_byte(8'h5A, "R2");
      send_byte(8'h40, "R8");
      send_byte(8'h3C, "R8");
      send_byte(8'h47, "R9");
      send_byte(8'h12, "R9");
      send_byte(8'h70, "R8");
      send_byte(8'hFF, "R8");
      send_byte(8'h55, "R8");
      send_byte(8'h66, "R8");

      // partial byte discarded by select release
      clock_bits(8'hFF, 3);
      select_high();
      select_low();
      send_byte(8'h81, "R6");

      // pending second byte dropped by select release
      send_byte(8'h7E, "R10");
      select_high();
      select_low();
      send_byte(8'h33, "R10");

      // edges with select high
      select_high();
      s0 = strobes;
      clock_bits(8'hC7, 8);
      clock_bits(8'h39, 8);
      wait_neg(10);
      chk(strobes == s0, "R7", "strobes while deselected", strobes, s0);
      select_low();
      send_byte(8'h18, "R7");

      // falling-edge capture
      set_mode(1'b1);
      select_low();
      send_byte(8'hC3, "R3");
      send_byte(8'h40, "R3");
      send_byte(8'h96, "R3");
      for (int n = 0; n < 30; n++) begin
         v = 8'($urandom());
         if (n % 4 == 0) v[7:4] = ($urandom() & 1) ? 4'h4 : 4'h7;
         send_byte(v, "R5");
      end

      // rising mode again, random with occasional select pulses
      set_mode(1'b0);
      select_low();
      for (int n = 0; n < 24; n++) begin
         v = 8'($urandom());
         if (n % 3 == 0) v[7:4] = 4'h4;
         if (n % 7 == 6) begin
            clock_bits(8'($urandom()), 1 + ($urandom() % 7));
            select_high();
            select_low();
         end
         send_byte(v, "R2");
      end

      wait_neg(10);
      chk(strobes == exp_strobes, "R4", "total strobes", strobes, exp_strobes);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule